// File: doc/BRIEF.md
# I/O Self-Test Pattern Generator

This block is a bring-up aid for a chip whose host port is a 16-bit input word split over two byte-wide pins and an 8-bit output. Particular codes held on the input word make the output byte play a known sequence. A tester can then confirm every input and output pin without starting any arithmetic. A host that sees the expected sequence knows that the pins, the clock and the reset work.

Three codes are recognised. The first repeats a four-character ASCII tag. The second toggles the output between all-zeros and all-ones. The third counts down from a start value taken from the low input byte. Each sequence restarts when its code first appears. When the input word is any other value, the output returns to zero on the next clock edge.

Top module: `io_selftest_gen`

## Requirements
- R1: A synchronous active-high reset drives the output to 0x00 and selects no mode. A code that is held through reset is treated as newly entered on the first edge after reset is released.
- R2: While the input word is 0xFFFF, the output repeats 0x54, 0x2D, 0x4E, 0x4E ('T','-','N','N'). The first edge with the code loaded gives 0x54.
- R3: While the input word is 0xF000, the output alternates 0x00 and 0xFF on successive edges, starting with 0x00.
- R4: When the high byte is 0xF1, the first edge gives the low byte. Each later edge with the high byte still 0xF1 lowers the output by one.
- R5: The countdown wraps from 0x00 to 0xFF and keeps decrementing.
- R6: While the high byte stays 0xF1 after entry, changes on the low byte have no effect on the count.
- R7: Any other input word gives 0x00 on the next edge. Near-miss codes such as 0xF001, 0xF2xx and 0xFFFE give 0x00, and so does 0x00F1, which has the bytes swapped. The first byte port is always the high byte of the word.
- R8: A change from one code straight to another, or a return to a code after a break, starts that code's sequence from its first element.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| hi_byte | input | 8 | High byte of the input word |
| lo_byte | input | 8 | Low byte of the input word |
| out_byte | output | 8 | Registered pattern output |

## Verification
The bench builds the block with its default code parameters: 0xFFFF, 0xF000 and 0xF1 as the high-byte prefix of the countdown. These values bring every documented code within reach. They also reach the near misses that differ from a code in one byte or one bit, and the swapped-byte word that tests which port is the high byte. A countdown that starts at 0x03 and a second that starts at 0x00 reach the wrap from 0x00 to 0xFF within a few cycles. Direct jumps between codes, and a reset applied while a code is held, exercise the restart rules.

// File: rtl/io_selftest_gen.sv
module io_selftest_gen #(
  parameter logic [15:0] TAG_CODE   = 16'hFFFF,
  parameter logic [15:0] ALT_CODE   = 16'hF000,
  parameter logic [7:0]  COUNT_HI   = 8'hF1
) (
  input  logic       clk,
  input  logic       rst,
  input  logic [7:0] hi_byte,
  input  logic [7:0] lo_byte,
  output logic [7:0] out_byte
);

  typedef enum logic [1:0] {M_IDLE, M_TAG, M_ALT, M_COUNT} mode_e;

  mode_e      mode_q, mode_d;
  logic [1:0] tag_idx_q;
  logic [7:0] out_q;
  logic [15:0] word;

  assign word = {hi_byte, lo_byte};

  function automatic logic [7:0] tag_char(input logic [1:0] idx);
    case (idx)
      2'd0:    tag_char = 8'h54;
      2'd1:    tag_char = 8'h2D;
      default: tag_char = 8'h4E;
    endcase
  endfunction

  always_comb begin
    if (word == TAG_CODE)           mode_d = M_TAG;
    else if (word == ALT_CODE)      mode_d = M_ALT;
    else if (hi_byte == COUNT_HI)   mode_d = M_COUNT;
    else                            mode_d = M_IDLE;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      mode_q    <= M_IDLE;
      tag_idx_q <= 2'd0;
      out_q     <= 8'h00;
    end else begin
      mode_q <= mode_d;
      if (mode_d != mode_q) begin
        tag_idx_q <= 2'd1;
        case (mode_d)
          M_TAG:   out_q <= tag_char(2'd0);
          M_COUNT: out_q <= lo_byte;
          default: out_q <= 8'h00;
        endcase
      end else begin
        case (mode_d)
          M_TAG: begin
            out_q     <= tag_char(tag_idx_q);
            tag_idx_q <= tag_idx_q + 2'd1;
          end
          M_ALT:   out_q <= ~out_q;
          M_COUNT: out_q <= out_q - 8'd1;
          default: out_q <= 8'h00;
        endcase
      end
    end
  end

  assign out_byte = out_q;

endmodule

// File: rtl/io_selftest_gen_chk.sv
module io_selftest_gen_chk (
  input logic       clk,
  input logic       rst,
  input logic [7:0] hi_byte,
  input logic [7:0] lo_byte,
  input logic [7:0] out_byte
);
  logic [15:0] w;
  logic is_tag, is_alt, is_cnt, is_idle;
  assign w       = {hi_byte, lo_byte};
  assign is_tag  = (w == 16'hFFFF);
  assign is_alt  = (w == 16'hF000);
  assign is_cnt  = (hi_byte == 8'hF1);
  assign is_idle = !is_tag && !is_alt && !is_cnt;

  AST_RESET_CLEARS: assert property (@(posedge clk) rst |=> out_byte == 8'h00); // R1
  AST_TAG_START: assert property (@(posedge clk) disable iff (rst)
    (is_tag && ($past(rst) || !$past(is_tag))) |=> out_byte == 8'h54); // R2
  AST_TAG_STEP: assert property (@(posedge clk) disable iff (rst)
    (is_tag && !$past(rst) && $past(is_tag) && out_byte == 8'h54) |=> out_byte == 8'h2D); // R2
  AST_ALT_START: assert property (@(posedge clk) disable iff (rst)
    (is_alt && ($past(rst) || !$past(is_alt))) |=> out_byte == 8'h00); // R3
  AST_ALT_TOGGLE: assert property (@(posedge clk) disable iff (rst)
    (is_alt && !$past(rst) && $past(is_alt)) |=> out_byte == ~$past(out_byte)); // R3
  AST_COUNT_START: assert property (@(posedge clk) disable iff (rst)
    (is_cnt && ($past(rst) || !$past(is_cnt))) |=> out_byte == $past(lo_byte)); // R8
  AST_COUNT_STEP: assert property (@(posedge clk) disable iff (rst)
    (is_cnt && !$past(rst) && $past(is_cnt)) |=> out_byte == $past(out_byte) - 8'd1); // R4
  AST_IDLE_ZERO: assert property (@(posedge clk) disable iff (rst)
    is_idle |=> out_byte == 8'h00); // R7
endmodule

bind io_selftest_gen io_selftest_gen_chk u_chk (.*);

// File: tb/io_selftest_gen_bench.sv
module io_selftest_gen_bench;
  logic clk = 1'b0;
  logic rst;
  logic [7:0] hi_byte, lo_byte;
  logic [7:0] out_byte;
  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  io_selftest_gen u_io_selftest_gen (
    .clk(clk), .rst(rst), .hi_byte(hi_byte), .lo_byte(lo_byte), .out_byte(out_byte)
  );

  // {hi, lo, expected output after the next edge, requirement number}
  localparam logic [31:0] VEC [25] = '{
    {8'hFF, 8'hFF, 8'h54, 8'd2},  // R2 entry
    {8'hFF, 8'hFF, 8'h2D, 8'd2},
    {8'hFF, 8'hFF, 8'h4E, 8'd2},
    {8'hFF, 8'hFF, 8'h4E, 8'd2},
    {8'hFF, 8'hFF, 8'h54, 8'd2},  // R2 loop back
    {8'h00, 8'h00, 8'h00, 8'd7},  // R7
    {8'hF0, 8'h00, 8'h00, 8'd3},  // R3 entry
    {8'hF0, 8'h00, 8'hFF, 8'd3},
    {8'hF0, 8'h00, 8'h00, 8'd3},
    {8'hF1, 8'h03, 8'h03, 8'd4},  // R4 entry
    {8'hF1, 8'h03, 8'h02, 8'd4},
    {8'hF1, 8'hAA, 8'h01, 8'd6},  // R6 low byte change ignored
    {8'hF1, 8'hAA, 8'h00, 8'd5},
    {8'hF1, 8'hAA, 8'hFF, 8'd5},  // R5 wrap
    {8'hF1, 8'hAA, 8'hFE, 8'd5},
    {8'hF0, 8'h01, 8'h00, 8'd7},  // R7 near miss
    {8'h00, 8'hF1, 8'h00, 8'd7},  // R7 swapped bytes
    {8'hFF, 8'hFF, 8'h54, 8'd8},
    {8'hF0, 8'h00, 8'h00, 8'd8},  // R8 direct switch
    {8'hFF, 8'hFF, 8'h54, 8'd8},  // R8 restart
    {8'hFF, 8'hFF, 8'h2D, 8'd8},
    {8'hF1, 8'h00, 8'h00, 8'd8},  // R8 countdown from zero
    {8'hF1, 8'h00, 8'hFF, 8'd5},
    {8'hF2, 8'hFF, 8'h00, 8'd7},
    {8'hFF, 8'hFE, 8'h00, 8'd7}
  };

  task automatic check(input logic [7:0] exp, input int req);
    checks++;
    if (out_byte !== exp) begin
      failures++;
      $display("FAIL R%0d: out_byte=%02h expected=%02h", req, out_byte, exp);
    end
  endtask

  task automatic step(input logic [7:0] h, input logic [7:0] l, input logic [7:0] exp, input int req);
    hi_byte = h;
    lo_byte = l;
    @(negedge clk);
    check(exp, req);
  endtask

  initial begin
    rst = 1'b1;
    hi_byte = 8'hFF;
    lo_byte = 8'hFF;
    repeat (3) @(negedge clk);
    check(8'h00, 1);  // R1 reset state while a code is held
    rst = 1'b0;
    @(negedge clk);
    check(8'h54, 1);  // R1 held code enters after reset release
    rst = 1'b1;
    @(negedge clk);
    rst = 1'b0;
    hi_byte = 8'h00;
    lo_byte = 8'h00;
    @(negedge clk);

    for (int i = 0; i < 25; i++)
      step(VEC[i][31:24], VEC[i][23:16], VEC[i][15:8], int'(VEC[i][7:0]));

    // R1 reset during countdown, then R8 restart from the low byte
    step(8'hF1, 8'h55, 8'h55, 4);
    step(8'hF1, 8'h55, 8'h54, 4);
    rst = 1'b1;
    @(negedge clk);
    check(8'h00, 1);  // R1
    rst = 1'b0;
    @(negedge clk);
    check(8'h55, 8);  // R8
    step(8'hF1, 8'h10, 8'h54, 6);  // R6

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk);
    if (!done) begin
      checks++;
      failures++;
      $display("FAIL watchdog: out_byte=%02h expected=completion", out_byte);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule